// File: doc/BRIEF.md
# Reset Sequencer with Status Interrupt

This block orders the two ways a register-based peripheral can be returned to its default state. One way is an external active-low pin, qualified by a minimum low width. The other is a self-clearing command bit in a configuration register. Both requests are accepted only while the power-mode code says the device is at full power. An accepted request emits a one-cycle load strobe for the register defaults. A hardware request also emits a second strobe for the registers that survive a software request. The block then runs a fixed transition period.

When the period ends, a sticky done flag is raised and an active-low interrupt is asserted. Software clears the flag by writing a one to it. The DSP run flag drops on every reset and stays low until software writes the start value. The block also keeps the serial-port selection and its lock. A software reset keeps a locked selection. A hardware reset always returns the selection to the default port and clears the lock.

Top module: `rst_seq`

## Requirements
- R1: The reset pin is acted on only while `pwr_mode_i` is 0 (full power). A low pulse of any width in modes 1 to 3 does not start a reset.
- R2: A hardware reset starts only on the rising edge of the pin that ends a low period of at least MIN_LOW clock cycles. MIN_LOW is 1250 at the defaults, which is 10 µs at 125 MHz. A shorter low pulse is ignored.
- R3: A hardware reset pulses `full_rst_o` and `dflt_load_o` together for one cycle. It clears the port lock and returns the selection to I2C (`port_spi_o` = 0).
- R4: Writing address 0x10 with bit 7 set, in mode 0, starts a software reset. `dflt_load_o` pulses for one cycle and `full_rst_o` stays low. `swrst_o` reads 1 during the transition and 0 once it ends.
- R5: A software reset keeps `port_spi_o` if `port_lock_o` is 1. If the port is unlocked, it returns `port_spi_o` to 0.
- R6: A software-reset write in modes 1 to 3 has no effect: no strobe, `swrst_o` stays 0, and `rst_done_o` is unchanged.
- R7: `rst_done_o` is 0 during the transition and becomes 1 exactly TRANS_CYC cycles (64 at the defaults) after the clock edge that accepted the request. `irq_no` is the inverse of `rst_done_o`.
- R8: Writing address 0x11 with bit 15 set clears `rst_done_o` and releases `irq_no` high. A write with bit 15 at 0 leaves it unchanged.
- R9: Every reset clears `dsp_run_o`. Outside a transition, writing 0x0001 to address 0x12 sets it and writing any other value clears it. It stays 0 during a transition.
- R10: A new request accepted during a transition restarts the full period from that edge.
- R11: A write to address 0x13 sets `port_spi_o` from bit 0 and `port_lock_o` from bit 1. Once the lock is set, further writes there are ignored until a hardware reset.
- R12: After the system reset `rst_ni`, the outputs are as follows: `rst_done_o`, `dsp_run_o`, `swrst_o`, `port_spi_o`, `port_lock_o` and both strobes are 0, and `irq_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| ext_rst_ni | input | 1 | Asynchronous active-low external reset pin |
| pwr_mode_i | input | 2 | Power-mode code, 0 = full power |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | DW | Register write data |
| dflt_load_o | output | 1 | One-cycle load of register defaults |
| full_rst_o | output | 1 | One-cycle load of hardware-only defaults |
| swrst_o | output | 1 | Software-reset bit of the configuration register |
| rst_done_o | output | 1 | Sticky reset-done flag |
| irq_no | output | 1 | Active-low interrupt |
| dsp_run_o | output | 1 | DSP run enable |
| port_spi_o | output | 1 | Serial-port selection, 1 = SPI |
| port_lock_o | output | 1 | Serial-port selection lock |

## Verification
Some properties are checked on every cycle by the assertions:
- the full-reset strobe never fires without the default-load strobe, and only after full power was sampled;
- the done flag rises only out of a running transition and is low while a load strobe is out;
- the run flag stays low during a transition;
- the lock falls only with a hardware reset.

Other behaviour can only be shown by the bench scenarios: the exact transition length, the restart on a second request, the pulse-width threshold on both sides, the mode gating of both reset kinds, and the different treatment of a locked port by the two reset kinds.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    PM_FULL = 2'd0,
    PM_LOW1 = 2'd1,
    PM_LOW2 = 2'd2,
    PM_LOW3 = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic spi;
    logic lock;
  } port_cfg_t;

  localparam int unsigned CFG_SWRST_BIT = 7;
  localparam int unsigned STAT_DONE_BIT = 15;
  localparam int unsigned PORT_SEL_BIT  = 0;
  localparam int unsigned PORT_LOCK_BIT = 1;
endpackage

// File: rtl/rstseq_pin_qual.sv
module rstseq_pin_qual #(
  parameter int unsigned MIN_LOW = 1250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ni,
  input  logic full_pwr_i,
  output logic hw_req_o
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);

  logic [2:0]    sync_q;
  logic [CW-1:0] low_cnt_q;
  logic          pin_s, pin_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], pin_ni};
  end

  assign pin_s    = sync_q[1];
  assign pin_prev = sync_q[2];

  // low time only accrues while at full power
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   low_cnt_q <= '0;
    else if (pin_s || !full_pwr_i) low_cnt_q <= '0;
    else if (low_cnt_q != CW'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign hw_req_o = pin_s && !pin_prev && full_pwr_i && (low_cnt_q == CW'(MIN_LOW));

  AST_LOW_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_cnt_q <= CW'(MIN_LOW)); // R2
  AST_REQ_AFTER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_req_o |-> $past(low_cnt_q) != 0); // R2
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int unsigned TRANS_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned TW = (TRANS_CYC > 1) ? $clog2(TRANS_CYC) : 1;

  logic [TW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= TW'(TRANS_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0) && !start_i;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(TRANS_CYC - 1)); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R7
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R10
endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
  import rstseq_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter logic [AW-1:0] CFG_ADDR  = 8'h10,
  parameter logic [AW-1:0] STAT_ADDR = 8'h11,
  parameter logic [AW-1:0] RUN_ADDR  = 8'h12,
  parameter logic [AW-1:0] PORT_ADDR = 8'h13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          full_pwr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          hw_req_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          sw_req_o,
  output logic          dflt_load_o,
  output logic          full_rst_o,
  output logic          swrst_o,
  output logic          rst_done_o,
  output logic          dsp_run_o,
  output logic          port_spi_o,
  output logic          port_lock_o
);
  logic      start;
  logic      wr_stat, wr_run, wr_port;
  logic      load_q, full_q, swrst_q, done_q, run_q;
  port_cfg_t port_q;

  assign sw_req_o = wr_en_i && (wr_addr_i == CFG_ADDR) && wr_data_i[CFG_SWRST_BIT] && full_pwr_i;
  assign start    = hw_req_i || sw_req_o;
  assign wr_stat  = wr_en_i && (wr_addr_i == STAT_ADDR) && wr_data_i[STAT_DONE_BIT];
  assign wr_run   = wr_en_i && (wr_addr_i == RUN_ADDR) && !busy_i;
  assign wr_port  = wr_en_i && (wr_addr_i == PORT_ADDR) && !busy_i && !port_q.lock;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q  <= 1'b0;
      full_q  <= 1'b0;
      swrst_q <= 1'b0;
      done_q  <= 1'b0;
      run_q   <= 1'b0;
      port_q  <= '0;
    end else begin
      load_q <= start;
      full_q <= hw_req_i;
      if (start) begin
        done_q  <= 1'b0;
        run_q   <= 1'b0;
        swrst_q <= !hw_req_i;
        if (hw_req_i)         port_q     <= '0;
        else if (!port_q.lock) port_q.spi <= 1'b0;
      end else begin
        if (done_i) begin
          done_q  <= 1'b1;
          swrst_q <= 1'b0;
        end else if (wr_stat) begin
          done_q  <= 1'b0;
        end
        if (wr_run)  run_q <= (wr_data_i == DW'(1));
        if (wr_port) begin
          port_q.spi  <= wr_data_i[PORT_SEL_BIT];
          port_q.lock <= wr_data_i[PORT_LOCK_BIT];
        end
      end
    end
  end

  assign dflt_load_o = load_q;
  assign full_rst_o  = full_q;
  assign swrst_o     = swrst_q;
  assign rst_done_o  = done_q;
  assign dsp_run_o   = run_q;
  assign port_spi_o  = port_q.spi;
  assign port_lock_o = port_q.lock;

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dflt_load_o |-> !rst_done_o); // R7
  AST_FULL_WITH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> dflt_load_o); // R3
  AST_DONE_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_done_o) |-> $past(busy_i)); // R7
  AST_RUN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !dsp_run_o); // R9
  AST_LOCK_HW_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(port_lock_o) |-> full_rst_o); // R11
  AST_SWRST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(swrst_o) |-> (rst_done_o || full_rst_o)); // R4
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned DW          = 16,
  parameter int unsigned CLK_KHZ     = 125000,
  parameter int unsigned MIN_LOW_NS  = 10000,
  parameter int unsigned TRANS_CYC   = 64,
  parameter logic [AW-1:0] CFG_ADDR  = 8'h10,
  parameter logic [AW-1:0] STAT_ADDR = 8'h11,
  parameter logic [AW-1:0] RUN_ADDR  = 8'h12,
  parameter logic [AW-1:0] PORT_ADDR = 8'h13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_ni,
  input  logic [1:0]    pwr_mode_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          dflt_load_o,
  output logic          full_rst_o,
  output logic          swrst_o,
  output logic          rst_done_o,
  output logic          irq_no,
  output logic          dsp_run_o,
  output logic          port_spi_o,
  output logic          port_lock_o
);
  localparam longint unsigned MIN_LOW_L = (longint'(CLK_KHZ) * MIN_LOW_NS) / 1000000;
  localparam int unsigned     MIN_LOW   = (MIN_LOW_L < 1) ? 1 : int'(MIN_LOW_L);

  logic full_pwr, hw_req, sw_req, busy, done;

  assign full_pwr = (pwr_mode_e'(pwr_mode_i) == PM_FULL);

  rstseq_pin_qual #(.MIN_LOW(MIN_LOW)) u_pin (
    .clk_i, .rst_ni,
    .pin_ni     (ext_rst_ni),
    .full_pwr_i (full_pwr),
    .hw_req_o   (hw_req)
  );

  rstseq_timer #(.TRANS_CYC(TRANS_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .start_i (hw_req || sw_req),
    .busy_o  (busy),
    .done_o  (done)
  );

  rstseq_regs #(
    .AW(AW), .DW(DW), .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR),
    .RUN_ADDR(RUN_ADDR), .PORT_ADDR(PORT_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .full_pwr_i  (full_pwr),
    .wr_en_i, .wr_addr_i, .wr_data_i,
    .hw_req_i    (hw_req),
    .busy_i      (busy),
    .done_i      (done),
    .sw_req_o    (sw_req),
    .dflt_load_o, .full_rst_o, .swrst_o, .rst_done_o, .dsp_run_o,
    .port_spi_o, .port_lock_o
  );

  assign irq_no = !rst_done_o;

  AST_HW_FULL_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_rst_o |-> ($past(pwr_mode_i) == 2'd0)); // R1
  AST_SW_FULL_PWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swrst_o) |-> ($past(pwr_mode_i) == 2'd0)); // R6
endmodule

// File: tb/sim_rst_seq.sv
module sim_rst_seq;
  localparam int T       = 64;
  localparam int MIN_LOW = 1250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_n = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic dflt_load, full_rst, swrst, rst_done, irq_n, dsp_run, port_spi, port_lock;

  int n_chk = 0, n_err = 0, n_full = 0, n_load = 0;
  bit m_run, m_done, m_spi, m_lock;

  always #4 clk = ~clk;

  rst_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(pin_n), .pwr_mode_i(mode),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .dflt_load_o(dflt_load), .full_rst_o(full_rst), .swrst_o(swrst),
    .rst_done_o(rst_done), .irq_no(irq_n), .dsp_run_o(dsp_run),
    .port_spi_o(port_spi), .port_lock_o(port_lock)
  );

  always @(negedge clk) begin
    n_full += int'(full_rst);
    n_load += int'(dflt_load);
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int low_cyc);
    pin_n = 1'b0;
    cyc(low_cyc);
    pin_n = 1'b1;
    cyc(8);
  endtask

  function automatic bit f_run(logic [15:0] d);
    return d == 16'h0001;
  endfunction

  task automatic chk_model(string tag);
    chk({tag, " run"},  dsp_run,   m_run);
    chk({tag, " done"}, rst_done,  m_done);
    chk({tag, " irq"},  irq_n,     !m_done);
    chk({tag, " spi"},  port_spi,  m_spi);
    chk({tag, " lock"}, port_lock, m_lock);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int nf, nl;
    void'($urandom(32'h5EED_1234));
    cyc(3);
    // R12 reset state
    chk("R12 done", rst_done, 0); chk("R12 irq", irq_n, 1);
    chk("R12 run", dsp_run, 0);   chk("R12 swrst", swrst, 0);
    chk("R12 port", {port_spi, port_lock}, 0);
    chk("R12 strobes", {dflt_load, full_rst}, 0);
    rst_n = 1'b1;
    cyc(2);

    // R4 R7 software reset timing
    wr(8'h10, 16'h0080);
    chk("R4 load", dflt_load, 1); chk("R4 no full", full_rst, 0); chk("R4 swrst", swrst, 1);
    cyc(T - 1);
    chk("R7 done low in transition", rst_done, 0);
    cyc(1);
    chk("R7 done at end", rst_done, 1); chk("R7 irq", irq_n, 0); chk("R4 swrst clear", swrst, 0);

    // R8 status clear
    wr(8'h11, 16'h7FFF); chk("R8 zero bit keeps", rst_done, 1);
    wr(8'h11, 16'h8000); chk("R8 clear", rst_done, 0); chk("R8 irq high", irq_n, 1);

    // R9 run register
    wr(8'h12, 16'h0001); chk("R9 start", dsp_run, 1);
    wr(8'h12, 16'h0002); chk("R9 other value", dsp_run, 0);
    wr(8'h12, 16'h0001); chk("R9 start again", dsp_run, 1);

    // R5 unlocked selection returns to default
    wr(8'h13, 16'h0001); chk("R11 sel", {port_spi, port_lock}, 2'b10);
    wr(8'h10, 16'h0080); chk("R9 run cleared", dsp_run, 0);
    cyc(T);
    chk("R5 unlocked to I2C", port_spi, 0);

    // R11 lock, R5 locked selection kept
    wr(8'h13, 16'h0003); chk("R11 locked", {port_spi, port_lock}, 2'b11);
    wr(8'h13, 16'h0000); chk("R11 write ignored", {port_spi, port_lock}, 2'b11);
    wr(8'h12, 16'h0001);
    wr(8'h10, 16'h0080);
    chk("R9 cleared by sw", dsp_run, 0);
    wr(8'h12, 16'h0001); chk("R9 run write ignored in transition", dsp_run, 0);
    cyc(T);
    chk("R5 locked kept", {port_spi, port_lock}, 2'b11);
    wr(8'h11, 16'h8000);

    // R6 software reset in low-power modes
    for (int m = 1; m < 4; m++) begin
      mode = m[1:0];
      nl = n_load;
      wr(8'h10, 16'h0080);
      cyc(3);
      chk("R6 no load", n_load - nl, 0); chk("R6 swrst", swrst, 0); chk("R6 done", rst_done, 0);
    end

    // R1 pin ignored in low-power mode
    mode = 2'd1;
    nf = n_full; nl = n_load;
    pulse(MIN_LOW + 20);
    chk("R1 no full", n_full - nf, 0); chk("R1 no load", n_load - nl, 0);
    chk("R1 lock kept", port_lock, 1);

    // R2 short pulse ignored
    mode = 2'd0;
    pulse(MIN_LOW - 20);
    chk("R2 short ignored", n_full - nf, 0); chk("R2 lock kept", port_lock, 1);

    // R3 qualified pulse
    wr(8'h12, 16'h0001);
    pulse(MIN_LOW + 20);
    chk("R3 one full", n_full - nf, 1); chk("R3 one load", n_load - nl, 1);
    chk("R3 port default", {port_spi, port_lock}, 2'b00);
    chk("R3 swrst", swrst, 0); chk("R9 run cleared by hw", dsp_run, 0);
    cyc(T);
    chk("R3 done", rst_done, 1);

    // R10 restart
    wr(8'h11, 16'h8000);
    wr(8'h10, 16'h0080);
    cyc(30);
    wr(8'h10, 16'h0080);
    cyc(T - 1);
    chk("R10 still in transition", rst_done, 0);
    cyc(1);
    chk("R10 done after restart", rst_done, 1);

    // random register traffic at full power
    m_run = 0; m_done = 1; m_spi = 0; m_lock = 0;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom_range(0, 4));
      d  = 16'($urandom);
      case (op)
        0: begin
          if ($urandom_range(0, 1) == 1) d = 16'h0001;
          wr(8'h12, d); m_run = f_run(d);
        end
        1: begin wr(8'h11, d); if (d[15]) m_done = 0; end
        2: begin
          wr(8'h13, d);
          if (!m_lock) begin m_spi = d[0]; m_lock = d[1]; end
        end
        3: wr(8'h10, d & 16'hFF7F);
        default: begin
          if ($urandom_range(0, 3) == 0) begin
            wr(8'h10, d | 16'h0080);
            m_run = 0; m_done = 0;
            if (!m_lock) m_spi = 0;
            chk("R7 rand transition", rst_done, 0);
            cyc(T);
            m_done = 1;
          end
        end
      endcase
      chk_model("R8 R9 R11 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule